// File: doc/BRIEF.md
# Self-Refresh Entry/Exit Timing Sequencer

This block takes a memory device into self-refresh and back out again. It enforces four minimum-time windows, each counted in controller clock cycles. An entry request makes the block issue a one-cycle entry command strobe and drive clock-enable (`cke`) low. The memory clock stays enabled for a programmed number of cycles after that, and only then is it switched off. An exit request first turns the memory clock back on and holds it for a programmed stabilisation time. The exit command strobe is issued only once that time has passed and the programmed minimum `cke` low time has been met. After exit, `cke` is held high for a minimum level time before the block reports ready again.

All four windows come from one 32-bit configuration word that software writes. The same word carries a half-rate mode bit. When that bit is set, the block halves and rounds up the stabilisation window and the `cke` level window. Writes to the word are accepted only while the block is idle.

The controller is a seven-state machine:
- IDLE is the ready state.
- SRE issues the entry strobe.
- CLK_KEEP holds the clock after entry.
- RESIDE is the self-refresh residency with the clock off.
- CLK_WAKE re-enables the clock before exit.
- SRX issues the exit strobe.
- CKE_SETTLE holds `cke` high.

The transitions are:
- IDLE→SRE on an entry request.
- SRE→CLK_KEEP always.
- CLK_KEEP→RESIDE when the keep window ends.
- RESIDE→CLK_WAKE on a live or pending exit request.
- CLK_WAKE→SRX when both the wake window and the `cke`-low minimum are met.
- SRX→CKE_SETTLE always.
- CKE_SETTLE→IDLE when the level window ends.

Top module: `sr_timing_seq`

## Requirements
- R1: After reset, `ready`=1, `cke`=1, `mclk_en`=1, both strobes are 0, and `cfg_rdata` reads 0x05050403. This means wake window 5, keep window 5, self-refresh `cke`-low minimum 4, `cke` level minimum 3, and half-rate off.
- R2: The configuration word layout is:
  - wake (clock-stable-before-exit) window in bits 27:24;
  - keep (clock-hold-after-entry) window in bits 19:16;
  - self-refresh `cke`-low minimum in bits 13:8;
  - `cke` level minimum in bits 4:0;
  - half-rate mode in bit 31.
  All other bits read as 0. A write with `cfg_wr_en`=1 while `ready`=1 is visible on `cfg_rdata` in the next cycle.
- R3: A configuration write made while `ready`=0 is ignored.
- R4: `enter_req` sampled in IDLE produces exactly one `cmd_sre` cycle in the next cycle, with `cke`=0 and `ready`=0. `enter_req` is ignored in any other state.
- R5: After the `cmd_sre` cycle, `mclk_en` stays 1 for exactly the effective keep window. It then stays 0 until an exit begins.
- R6: Once an exit starts, `mclk_en` is 1 for at least the effective wake window before the `cmd_srx` cycle. It is exactly that window when the `cke`-low minimum is already met.
- R7: `cke` is 0 from the `cmd_sre` cycle up to the cycle before `cmd_srx`. That low span lasts at least max(effective self-refresh `cke`-low minimum, effective `cke` level minimum) cycles, and `cmd_srx` is delayed as far as needed to meet it.
- R8: An `exit_req` seen in SRE or CLK_KEEP is held pending and serviced from RESIDE. If the `cke`-low minimum is the limit, the exit lands exactly when that minimum is met. An `exit_req` in IDLE is ignored.
- R9: `cmd_srx` is a single cycle with `cke`=1. `ready` returns exactly the effective `cke` level minimum cycles after the `cmd_srx` cycle, and `cke` stays 1 throughout.
- R10: With half-rate set, the effective wake window and the effective `cke` level minimum are ceil(field/2). The keep window and the self-refresh `cke`-low minimum are not scaled.
- R11: A field whose effective value would be 0 acts as 1 cycle.
- R12: `cmd_sre` and `cmd_srx` are never 1 together. `mclk_en`=0 implies `cke`=0. `ready`=1 implies `cke`=1 and `mclk_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enter_req | input | 1 | Request to enter self-refresh |
| exit_req | input | 1 | Request to leave self-refresh |
| cfg_wr_en | input | 1 | Configuration word write enable |
| cfg_wdata | input | 32 | Configuration word write data |
| cfg_rdata | output | 32 | Current configuration word |
| cmd_sre | output | 1 | One-cycle self-refresh entry command |
| cmd_srx | output | 1 | One-cycle self-refresh exit command |
| cke | output | 1 | Memory clock-enable level |
| mclk_en | output | 1 | Memory clock valid/enable |
| ready | output | 1 | High only when idle |

## Verification
Every state decodes to a distinct combination of `cke`, `mclk_en`, `ready` and the strobes, so a wrong state shows at the ports in the same cycle it is entered. A wrong counter value shows up as a window that is too long or too short, and only when that window closes. That is between one and 63 cycles later, depending on the field. A lost or spurious pending exit changes how long the clock-off phase lasts, or moves `cmd_srx` away from the edge of the `cke`-low window. The bench therefore measures every window length from the ports and compares it exactly.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;

    parameter int unsigned WAKE_W   = 4;
    parameter int unsigned KEEP_W   = 4;
    parameter int unsigned SRLOW_W  = 6;
    parameter int unsigned LEVEL_W  = 5;
    parameter int unsigned WORD_W   = 32;

    parameter int unsigned WAKE_LSB  = 24;
    parameter int unsigned KEEP_LSB  = 16;
    parameter int unsigned SRLOW_LSB = 8;
    parameter int unsigned LEVEL_LSB = 0;
    parameter int unsigned HALF_BIT  = 31;

    parameter logic [WORD_W-1:0] CFG_RESET_WORD = 32'h0505_0403;

    localparam int unsigned MAX_AB = (WAKE_W > KEEP_W) ? WAKE_W : KEEP_W;
    localparam int unsigned MAX_CD = (SRLOW_W > LEVEL_W) ? SRLOW_W : LEVEL_W;
    localparam int unsigned CNT_W  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_SRE        = 3'd1,
        ST_CLK_KEEP   = 3'd2,
        ST_RESIDE     = 3'd3,
        ST_CLK_WAKE   = 3'd4,
        ST_SRX        = 3'd5,
        ST_CKE_SETTLE = 3'd6
    } sr_state_e;

    typedef struct packed {
        logic               half_rate;
        logic [WAKE_W-1:0]  t_wake;
        logic [KEEP_W-1:0]  t_keep;
        logic [SRLOW_W-1:0] t_srlow;
        logic [LEVEL_W-1:0] t_level;
    } sr_cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0] wake;
        logic [CNT_W-1:0] keep;
        logic [CNT_W-1:0] level;
        logic [CNT_W-1:0] low_min;
    } sr_eff_t;

    function automatic sr_cfg_t cfg_from_word(input logic [WORD_W-1:0] w);
        sr_cfg_t c;
        c.half_rate = w[HALF_BIT];
        c.t_wake    = w[WAKE_LSB  +: WAKE_W];
        c.t_keep    = w[KEEP_LSB  +: KEEP_W];
        c.t_srlow   = w[SRLOW_LSB +: SRLOW_W];
        c.t_level   = w[LEVEL_LSB +: LEVEL_W];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] word_from_cfg(input sr_cfg_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[HALF_BIT]                = c.half_rate;
        w[WAKE_LSB  +: WAKE_W]     = c.t_wake;
        w[KEEP_LSB  +: KEEP_W]     = c.t_keep;
        w[SRLOW_LSB +: SRLOW_W]    = c.t_srlow;
        w[LEVEL_LSB +: LEVEL_W]    = c.t_level;
        return w;
    endfunction

endpackage

// File: rtl/sr_cfg_regs.sv
module sr_cfg_regs
    import sr_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_allow,
    input  logic [WORD_W-1:0] wdata,
    output sr_cfg_t           cfg,
    output logic [WORD_W-1:0] rdata
);

    sr_cfg_t cfg_q;

    // Field storage; updates only when the sequencer is idle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= cfg_from_word(CFG_RESET_WORD);
        end else if (wr_en && wr_allow) begin
            cfg_q <= cfg_from_word(wdata);
        end
    end

    assign cfg   = cfg_q;
    assign rdata = word_from_cfg(cfg_q);

endmodule

// File: rtl/sr_eff_calc.sv
module sr_eff_calc
    import sr_seq_pkg::*;
(
    input  sr_cfg_t cfg,
    output sr_eff_t eff
);

    // Optional halving with round-up, then a floor of one cycle.
    function automatic logic [CNT_W-1:0] win_len(input logic [CNT_W-1:0] raw,
                                                 input logic             halve);
        logic [CNT_W:0] t;
        if (halve) begin
            t = ({1'b0, raw} + (CNT_W+1)'(1)) >> 1;
        end else begin
            t = {1'b0, raw};
        end
        if (t == '0) begin
            return CNT_W'(1);
        end
        return t[CNT_W-1:0];
    endfunction

    logic [CNT_W-1:0] srlow_eff;

    always_comb begin
        eff.wake  = win_len(CNT_W'(cfg.t_wake),  cfg.half_rate);
        eff.keep  = win_len(CNT_W'(cfg.t_keep),  1'b0);
        eff.level = win_len(CNT_W'(cfg.t_level), cfg.half_rate);
        srlow_eff = win_len(CNT_W'(cfg.t_srlow), 1'b0);
        // CKE low span must cover both the self-refresh and level minimums.
        eff.low_min = (srlow_eff > eff.level) ? srlow_eff : eff.level;
    end

endmodule

// File: rtl/sr_win_cnt.sv
module sr_win_cnt #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);

    logic [W-1:0] cnt_q;

    // Saturating down-counter; the cycle with count <= 1 is the final one.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign last = (cnt_q <= W'(1));

endmodule

// File: rtl/sr_timing_seq.sv
module sr_timing_seq
    import sr_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enter_req,
    input  logic        exit_req,
    input  logic        cfg_wr_en,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        cmd_sre,
    output logic        cmd_srx,
    output logic        cke,
    output logic        mclk_en,
    output logic        ready
);

    sr_state_e        st_q;
    sr_state_e        st_nxt;
    sr_cfg_t          cfg;
    sr_eff_t          eff;
    logic             win_load;
    logic [CNT_W-1:0] win_val;
    logic             win_last;
    logic             low_load;
    logic [CNT_W-1:0] low_val;
    logic             low_last;
    logic             exit_pend_q;

    sr_cfg_regs u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .wr_allow (st_q == ST_IDLE),
        .wdata    (cfg_wdata),
        .cfg      (cfg),
        .rdata    (cfg_rdata)
    );

    sr_eff_calc u_eff (
        .cfg (cfg),
        .eff (eff)
    );

    // Shared window counter for keep, wake and level-settle phases.
    sr_win_cnt #(.W(CNT_W)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (win_load),
        .load_val (win_val),
        .last     (win_last)
    );

    // CKE-low span counter, started in SRE with one cycle already spent.
    sr_win_cnt #(.W(CNT_W)) u_low (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (low_load),
        .load_val (low_val),
        .last     (low_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nxt;
        end
    end

    // Pending exit: captured before residency, dropped on the way to CLK_WAKE.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exit_pend_q <= 1'b0;
        end else if (st_nxt == ST_CLK_WAKE) begin
            exit_pend_q <= 1'b0;
        end else if (exit_req && (st_q == ST_SRE || st_q == ST_CLK_KEEP)) begin
            exit_pend_q <= 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE:       if (enter_req)                st_nxt = ST_SRE;
            ST_SRE:                                      st_nxt = ST_CLK_KEEP;
            ST_CLK_KEEP:   if (win_last)                 st_nxt = ST_RESIDE;
            ST_RESIDE:     if (exit_req || exit_pend_q)  st_nxt = ST_CLK_WAKE;
            ST_CLK_WAKE:   if (win_last && low_last)     st_nxt = ST_SRX;
            ST_SRX:                                      st_nxt = ST_CKE_SETTLE;
            ST_CKE_SETTLE: if (win_last)                 st_nxt = ST_IDLE;
            default:                                     st_nxt = ST_IDLE;
        endcase
    end

    // Counter loads happen on the edge that enters the timed phase.
    always_comb begin
        win_load = 1'b0;
        win_val  = '0;
        unique case (st_q)
            ST_SRE: begin
                win_load = 1'b1;
                win_val  = eff.keep;
            end
            ST_RESIDE: begin
                win_load = (st_nxt == ST_CLK_WAKE);
                win_val  = eff.wake;
            end
            ST_SRX: begin
                win_load = 1'b1;
                win_val  = eff.level;
            end
            default: begin
                win_load = 1'b0;
            end
        endcase
        low_load = (st_q == ST_SRE);
        low_val  = eff.low_min - CNT_W'(1);
    end

    // Output decode
    always_comb begin
        cmd_sre = 1'b0;
        cmd_srx = 1'b0;
        cke     = 1'b1;
        mclk_en = 1'b1;
        ready   = 1'b0;
        unique case (st_q)
            ST_IDLE:       ready = 1'b1;
            ST_SRE: begin
                cmd_sre = 1'b1;
                cke     = 1'b0;
            end
            ST_CLK_KEEP:   cke = 1'b0;
            ST_RESIDE: begin
                cke     = 1'b0;
                mclk_en = 1'b0;
            end
            ST_CLK_WAKE:   cke = 1'b0;
            ST_SRX:        cmd_srx = 1'b1;
            ST_CKE_SETTLE: begin end
            default:       ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/sr_timing_seq_chk.sv
module sr_timing_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        enter_req,
    input logic [31:0] cfg_rdata,
    input logic        cmd_sre,
    input logic        cmd_srx,
    input logic        cke,
    input logic        mclk_en,
    input logic        ready
);

    logic [7:0] low_run;
    logic [7:0] clk_run;
    logic [7:0] need_wake;
    logic [7:0] need_low;
    logic [7:0] lvl_eff;
    logic [7:0] srl_eff;
    logic [7:0] t8;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
            clk_run <= '0;
        end else begin
            low_run <= cke ? 8'd0 : ((low_run == 8'hFF) ? low_run : low_run + 8'd1);
            clk_run <= !mclk_en ? 8'd0 : ((clk_run == 8'hFF) ? clk_run : clk_run + 8'd1);
        end
    end

    always_comb begin
        t8        = cfg_rdata[31] ? ({4'd0, cfg_rdata[27:24]} + 8'd1) >> 1 : {4'd0, cfg_rdata[27:24]};
        need_wake = (t8 == 8'd0) ? 8'd1 : t8;
        t8        = cfg_rdata[31] ? ({3'd0, cfg_rdata[4:0]} + 8'd1) >> 1 : {3'd0, cfg_rdata[4:0]};
        lvl_eff   = (t8 == 8'd0) ? 8'd1 : t8;
        srl_eff   = (cfg_rdata[13:8] == 6'd0) ? 8'd1 : {2'd0, cfg_rdata[13:8]};
        need_low  = (srl_eff > lvl_eff) ? srl_eff : lvl_eff;
    end

    p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_sre && cmd_srx));
    p_clk_off_cke_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !mclk_en |-> !cke);
    p_ready_levels_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (cke && mclk_en));
    p_enter_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && enter_req) |=> (cmd_sre && !cke && !ready));
    p_cfg_frozen_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(cfg_rdata));
    p_wake_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_srx |-> (clk_run >= need_wake));
    p_low_span_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (low_run >= need_low));
    p_srx_cke_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_srx |-> (cke && !ready));
    p_keep_after_sre_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_sre |=> (mclk_en && !cmd_sre));

endmodule

bind sr_timing_seq sr_timing_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enter_req (enter_req),
    .cfg_rdata (cfg_rdata),
    .cmd_sre   (cmd_sre),
    .cmd_srx   (cmd_srx),
    .cke       (cke),
    .mclk_en   (mclk_en),
    .ready     (ready)
);

// File: tb/sim_sr_timing_seq.sv
`timescale 1ns/1ps
module sim_sr_timing_seq;

    localparam int CLK_P = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enter_req = 1'b0;
    logic        exit_req = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cmd_sre, cmd_srx, cke, mclk_en, ready;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // Port monitors
    int low_run = 0, last_low = 0;
    int mclk_run = 0, last_wake = 0;
    int hold_run = 0, last_keep = 0;
    bit after_sre = 0;
    int post_run = 0, last_post = 0;
    bit after_srx = 0;
    int sre_cnt = 0, srx_cnt = 0;

    always #(CLK_P/2) clk = ~clk;

    sr_timing_seq u0 (
        .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .exit_req(exit_req),
        .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cmd_sre(cmd_sre), .cmd_srx(cmd_srx), .cke(cke), .mclk_en(mclk_en),
        .ready(ready)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (!cke) low_run++;
            else begin
                if (low_run != 0) last_low = low_run;
                low_run = 0;
            end
            if (mclk_en) mclk_run++; else mclk_run = 0;
            if (cmd_srx) last_wake = mclk_run - 1;
            if (cmd_sre) begin
                after_sre = 1; hold_run = 0; sre_cnt++;
            end else if (after_sre) begin
                if (mclk_en) hold_run++;
                else begin last_keep = hold_run; after_sre = 0; end
            end
            if (cmd_srx) begin
                after_srx = 1; post_run = 0; srx_cnt++;
            end else if (after_srx) begin
                if (ready) begin last_post = post_run; after_srx = 0; end
                else post_run++;
            end
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [31:0] w);
        cfg_wr_en = 1'b1; cfg_wdata = w;
        step();
        cfg_wr_en = 1'b0;
    endtask

    task automatic sr_cycle(input bit early, input int dwell);
        enter_req = 1'b1;
        step();
        enter_req = 1'b0;
        if (early) begin
            exit_req = 1'b1;
            step();
            exit_req = 1'b0;
        end else begin
            for (int g = 0; g < 200 && mclk_en; g++) step();
            for (int d = 0; d < dwell; d++) step();
            exit_req = 1'b1;
            step();
            exit_req = 1'b0;
        end
        for (int g = 0; g < 500 && !ready; g++) step();
    endtask

    task automatic t_reset();
        check("R1", "ready", ready, 1);
        check("R1", "cke", cke, 1);
        check("R1", "mclk_en", mclk_en, 1);
        check("R1", "strobes", {cmd_sre, cmd_srx}, 0);
        check("R1", "cfg_rdata", cfg_rdata, 32'h0505_0403);
    endtask

    task automatic t_default_cycle();
        int s0 = sre_cnt;
        int x0 = srx_cnt;
        sr_cycle(1'b0, 3);
        check("R4", "sre pulses", sre_cnt - s0, 1);
        check("R5", "keep window", last_keep, 5);
        check("R6", "wake window", last_wake, 5);
        check("R7", "cke low span", last_low, 1 + 5 + 4 + 5);
        check("R9", "srx pulses", srx_cnt - x0, 1);
        check("R9", "level settle", last_post, 3);
    endtask

    task automatic t_layout();
        write_cfg(32'hFFFF_FFFF);
        check("R2", "all-ones readback", cfg_rdata, 32'h8F0F_3F1F);
        write_cfg(32'h0A03_2C11);
        check("R2", "field readback", cfg_rdata, 32'h0A03_2C11);
    endtask

    task automatic t_half_rate();
        write_cfg(32'h8505_0405);
        sr_cycle(1'b0, 2);
        check("R10", "keep unscaled", last_keep, 5);
        check("R10", "wake halved", last_wake, 3);
        check("R10", "level halved", last_post, 3);
    endtask

    task automatic t_zero();
        write_cfg(32'h0000_0000);
        sr_cycle(1'b0, 1);
        check("R11", "keep of zero", last_keep, 1);
        check("R11", "wake of zero", last_wake, 1);
        check("R11", "level of zero", last_post, 1);
    endtask

    task automatic t_pending_srlow();
        write_cfg(32'h0101_1402);
        sr_cycle(1'b1, 0);
        check("R8", "cke low span pending", last_low, 20);
        check("R8", "wake stretched", last_wake, 17);
        check("R5", "keep of one", last_keep, 1);
        check("R9", "level two", last_post, 2);
    endtask

    task automatic t_level_dominates();
        write_cfg(32'h0101_020A);
        sr_cycle(1'b1, 0);
        check("R7", "low span from level field", last_low, 10);
        check("R9", "level ten", last_post, 10);
    endtask

    task automatic t_ignored();
        int s0;
        int x0;
        write_cfg(32'h0302_0403);
        s0 = sre_cnt;
        enter_req = 1'b1;
        step();
        enter_req = 1'b0;
        for (int g = 0; g < 200 && mclk_en; g++) step();
        // Busy: write and re-entry request must both be dropped.
        cfg_wr_en = 1'b1; cfg_wdata = 32'h0000_0000; enter_req = 1'b1;
        step();
        cfg_wr_en = 1'b0; enter_req = 1'b0;
        check("R3", "cfg after busy write", cfg_rdata, 32'h0302_0403);
        check("R5", "clock still off", mclk_en, 0);
        exit_req = 1'b1;
        step();
        exit_req = 1'b0;
        for (int g = 0; g < 500 && !ready; g++) step();
        check("R4", "sre pulses with busy enter", sre_cnt - s0, 1);
        check("R3", "cfg after cycle", cfg_rdata, 32'h0302_0403);
        // Exit request in IDLE has no effect.
        x0 = srx_cnt;
        exit_req = 1'b1;
        for (int k = 0; k < 3; k++) step();
        exit_req = 1'b0;
        check("R8", "srx from idle exit", srx_cnt - x0, 0);
        check("R8", "ready stays", ready, 1);
        sr_cycle(1'b0, 4);
        check("R8", "wake window after idle exit", last_wake, 3);
        check("R5", "keep window two", last_keep, 2);
        check("R12", "ready levels", {ready, cke, mclk_en}, 3'b111);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 3; k++) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_default_cycle();
        t_layout();
        t_half_rate();
        t_zero();
        t_pending_srlow();
        t_level_dominates();
        t_ignored();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule